// File: doc/BRIEF.md
# Serial EEPROM command slave

This block is the device-side front end of a 256-word by 16-bit nonvolatile-style store, held here as a register array. It watches an active-low chip select, a serial clock and a serial data input, all oversampled on a fast system clock, and drives a data-out line expressed as a value plus an output enable. After selection it searches bit by bit for a fixed 1010 start pattern and ignores everything before it. It then shifts in a 4-bit opcode and an 8-bit address (or dummy) field, and for the two writing commands a further 16 data bits. All of these bits are taken on rising edges of the serial clock.

Reads are served directly from the array. The word goes out most significant bit first, one bit per falling serial clock edge, starting at the falling edge that closes the address field. A write-enable latch gates the two writing commands. A write of one word or of every word is handed to a separate program-cycle controller over a valid/ready request channel. The request holds its payload until it is accepted, and the array takes the new data in the cycle of acceptance. Back-pressure rule: while a request is pending, any further write that completes is dropped, and the sender must poll ready/busy before issuing the next write. An abort input cancels write frames but leaves reads and the enable latch alone. When the controller reports busy at selection time, data-out shows ready/busy status.

Top module: `sereep_slave`

## Requirements
- R1: While chip select has been high for three system clocks, and after reset, do_oe is 0. A selected slave that is neither reading nor reporting status also keeps do_oe at 0.
- R2: After chip select falls, all bits are ignored until the last four bits on di, taken at rising sk edges, equal 1,0,1,0 in that order. A frame preceded by junk bits 0,1,1 decodes normally.
- R3: Opcode 1000 (READ), sent most significant bit first and followed by an 8-bit address sent MSB first, makes do_oe rise after the falling sk edge that ends the 16th clock of the frame. The word at that address then appears on do_out MSB first, one bit per falling edge, and do_oe falls at the 17th falling edge.
- R4: The write-enable latch is clear after rst_n. Opcode 0100 (WRITE) or 0001 (write-all) with the latch clear raises no request and leaves the array unchanged.
- R5: Opcode 0011 sets the latch and opcode 0000 clears it. A write after 0000 raises no request. READ, 0011 and 0000 all work while wr_abort is high.
- R6: With the latch set, WRITE with address A and 16 data bits (MSB first) raises prog_valid after the 32nd rising sk edge, with prog_addr=A, prog_data set to the data and prog_all=0. A later READ of A returns the data once the request is accepted.
- R7: Write-all (0001, 8 dummy bits, 16 data bits) raises a request with prog_all=1. After acceptance every address reads back the data.
- R8: prog_valid stays high with stable payload until prog_ready is seen high. A write frame that completes while a request is pending is dropped.
- R9: Chip select rising in mid-frame discards the partial instruction, including a half-sent 0011.
- R10: wr_abort high at any time during a write frame cancels it: no request is raised and the array is unchanged.
- R11: If prog_busy is high when chip select falls, do_oe is 1 and do_out equals the inverse of prog_busy. This lasts until a rising sk edge with di=1 or until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sk |
| rst_n | input | 1 | Active-low power-up reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| sk | input | 1 | Serial clock (asynchronous) |
| di | input | 1 | Serial data in |
| wr_abort | input | 1 | High cancels write frames |
| do_out | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for the data-out driver |
| prog_busy | input | 1 | Program controller busy |
| prog_valid | output | 1 | Program request valid |
| prog_ready | input | 1 | Program controller accepts the request |
| prog_addr | output | 8 | Request address |
| prog_data | output | 16 | Request data |
| prog_all | output | 1 | Request covers every address |

## Verification
A corrupted frame counter or shift register shows up within one frame, as a wrong word, a wrong bit alignment on do_out, or a do_oe edge at the wrong falling sk edge. A wrong write-enable latch or abort flag appears at the request channel right after the 32nd clock of the next write, and it also shows in a later read of the targeted address. Payload that drifts under back-pressure is caught in the first cycle it changes, and leftover output-enable state is caught three system clocks after deselection.

// File: rtl/sereep_pkg.sv
package sereep_pkg;
  localparam int OPC_W = 4;
  localparam logic [3:0] START_PAT = 4'b1010;
  localparam logic [OPC_W-1:0] OPC_READ  = 4'b1000;
  localparam logic [OPC_W-1:0] OPC_WRITE = 4'b0100;
  localparam logic [OPC_W-1:0] OPC_WREN  = 4'b0011;
  localparam logic [OPC_W-1:0] OPC_WRDIS = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_WRALL = 4'b0001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HUNT, ST_OPC, ST_ADDR, ST_DATA, ST_RD, ST_DONE
  } frame_st_e;
endpackage

// File: rtl/sereep_sync.sv
module sereep_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q[0] <= RST_VAL;
    else        pipe_q[0] <= d_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[g] <= RST_VAL;
      else        pipe_q[g] <= pipe_q[g-1];
    end
  end

  assign d_out = pipe_q[STAGES-1];
endmodule

// File: rtl/sereep_frame.sv
module sereep_frame
  import sereep_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          sk_rise,
  input  logic          sk_fall,
  input  logic          di_s,
  input  logic          abort_s,
  input  logic          busy,
  input  logic          pend_free,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] word_addr,
  output logic [DW-1:0] word_data,
  output logic          fire,
  output logic          fire_all,
  output logic          do_out,
  output logic          do_oe,
  output logic          wen_q,
  output logic          abort_seen_q
);
  localparam int CW = $clog2(DW + 1);

  frame_st_e        state_q;
  logic [3:0]       hunt_q;
  logic [OPC_W-1:0] op_q;
  logic [CW-1:0]    cnt_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic [DW-1:0]    sh_q;
  logic             rd_oe_q;
  logic             stat_q;
  logic [3:0]       hunt_nx;
  logic             abort_any;

  always_comb begin
    hunt_nx   = {hunt_q[2:0], di_s};
    abort_any = abort_seen_q | abort_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      hunt_q       <= '0;
      op_q         <= '0;
      cnt_q        <= '0;
      addr_q       <= '0;
      data_q       <= '0;
      sh_q         <= '0;
      rd_oe_q      <= 1'b0;
      stat_q       <= 1'b0;
      wen_q        <= 1'b0;
      abort_seen_q <= 1'b0;
      fire         <= 1'b0;
      fire_all     <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (!sel) begin
        state_q <= ST_IDLE;
        rd_oe_q <= 1'b0;
        stat_q  <= 1'b0;
      end else begin
        if (abort_s) abort_seen_q <= 1'b1;
        unique case (state_q)
          ST_IDLE: begin
            state_q      <= ST_HUNT;
            hunt_q       <= '0;
            stat_q       <= busy;
            abort_seen_q <= abort_s;
          end
          ST_HUNT: if (sk_rise) begin
            hunt_q <= hunt_nx;
            if (di_s) stat_q <= 1'b0;
            if (hunt_nx == START_PAT) begin
              state_q <= ST_OPC;
              cnt_q   <= '0;
            end
          end
          ST_OPC: if (sk_rise) begin
            op_q <= {op_q[OPC_W-2:0], di_s};
            if (cnt_q == CW'(OPC_W - 1)) begin
              state_q <= ST_ADDR;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_ADDR: if (sk_rise) begin
            addr_q <= {addr_q[AW-2:0], di_s};
            if (cnt_q == CW'(AW - 1)) begin
              cnt_q <= '0;
              unique case (op_q)
                OPC_READ:  state_q <= ST_RD;
                OPC_WREN:  begin wen_q <= 1'b1; state_q <= ST_DONE; end
                OPC_WRDIS: begin wen_q <= 1'b0; state_q <= ST_DONE; end
                OPC_WRITE, OPC_WRALL:
                  state_q <= (wen_q && !abort_any) ? ST_DATA : ST_DONE;
                default:   state_q <= ST_DONE;
              endcase
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            if (abort_s) state_q <= ST_DONE;
            else if (sk_rise) begin
              data_q <= {data_q[DW-2:0], di_s};
              if (cnt_q == CW'(DW - 1)) begin
                fire     <= pend_free;
                fire_all <= (op_q == OPC_WRALL);
                state_q  <= ST_DONE;
              end else cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RD: if (sk_fall) begin
            if (cnt_q == '0) begin
              sh_q    <= rd_word;
              rd_oe_q <= 1'b1;
              cnt_q   <= CW'(1);
            end else if (cnt_q == CW'(DW)) begin
              rd_oe_q <= 1'b0;
              state_q <= ST_DONE;
            end else begin
              sh_q  <= {sh_q[DW-2:0], 1'b0};
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign word_addr = addr_q;
  assign word_data = data_q;
  assign do_oe     = rd_oe_q | stat_q;
  assign do_out    = rd_oe_q ? sh_q[DW-1] : ~busy;
endmodule

// File: rtl/sereep_req.sv
module sereep_req #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          fire_all,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  output logic          out_all,
  output logic          commit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      out_addr <= '0;
      out_data <= '0;
      out_all  <= 1'b0;
    end else begin
      if (valid && ready) valid <= 1'b0;
      if (fire && !valid) begin
        valid    <= 1'b1;
        out_addr <= in_addr;
        out_data <= in_data;
        out_all  <= fire_all;
      end
    end
  end

  assign commit = valid & ready;
endmodule

// File: rtl/sereep_store.sv
module sereep_store #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic          we_all,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we && (we_all || waddr == AW'(i))) mem_q[i] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/sereep_slave.sv
module sereep_slave #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sk,
  input  logic          di,
  input  logic          wr_abort,
  output logic          do_out,
  output logic          do_oe,
  input  logic          prog_busy,
  output logic          prog_valid,
  input  logic          prog_ready,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic          prog_all
);
  logic [3:0]    pins_s;
  logic          cs_s, sk_s, di_s, abort_s;
  logic          sk_d;
  logic          sk_rise, sk_fall;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_data;
  logic          f_fire, f_all;
  logic [DW-1:0] rd_word;
  logic          commit;
  logic          frame_wen, frame_abort;

  sereep_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({cs_n, sk, di, wr_abort}), .d_out(pins_s)
  );
  assign {cs_s, sk_s, di_s, abort_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_d <= 1'b0;
    else        sk_d <= sk_s;
  end
  assign sk_rise = sk_s & ~sk_d;
  assign sk_fall = ~sk_s & sk_d;

  sereep_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .sel(~cs_s), .sk_rise(sk_rise), .sk_fall(sk_fall),
    .di_s(di_s), .abort_s(abort_s), .busy(prog_busy), .pend_free(~prog_valid),
    .rd_word(rd_word), .word_addr(f_addr), .word_data(f_data),
    .fire(f_fire), .fire_all(f_all), .do_out(do_out), .do_oe(do_oe),
    .wen_q(frame_wen), .abort_seen_q(frame_abort)
  );

  sereep_req #(.AW(AW), .DW(DW)) u_req (
    .clk(clk), .rst_n(rst_n), .fire(f_fire), .fire_all(f_all),
    .in_addr(f_addr), .in_data(f_data), .ready(prog_ready),
    .valid(prog_valid), .out_addr(prog_addr), .out_data(prog_data),
    .out_all(prog_all), .commit(commit)
  );

  sereep_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .we(commit), .we_all(prog_all), .waddr(prog_addr),
    .wdata(prog_data), .raddr(f_addr), .rdata(rd_word)
  );
endmodule

// File: rtl/sereep_chk.sv
module sereep_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          do_oe,
  input logic          prog_valid,
  input logic          prog_ready,
  input logic [AW-1:0] prog_addr,
  input logic [DW-1:0] prog_data,
  input logic          prog_all,
  input logic          wen_q,
  input logic          abort_seen_q
);
  // R1: a deselected slave releases data-out
  assert_deselect_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !do_oe);

  // R8: a pending request keeps its payload until accepted
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && !prog_ready) |=>
      (prog_valid && $stable(prog_addr) && $stable(prog_data) && $stable(prog_all)));

  // R4: no request unless the enable latch was set
  assert_req_needs_wen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_valid) |-> $past(wen_q));

  // R10: no request from a frame that saw the abort input
  assert_abort_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_valid) |-> !$past(abort_seen_q));
endmodule

bind sereep_slave sereep_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .do_oe(do_oe),
  .prog_valid(prog_valid), .prog_ready(prog_ready), .prog_addr(prog_addr),
  .prog_data(prog_data), .prog_all(prog_all),
  .wen_q(frame_wen), .abort_seen_q(frame_abort)
);

// File: tb/tb_sereep_slave.sv
module tb_sereep_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sk = 1'b0, di = 1'b0, wr_abort = 1'b0;
  logic prog_busy = 1'b0, prog_ready = 1'b0;
  logic do_out, do_oe, prog_valid, prog_all;
  logic [7:0] prog_addr;
  logic [15:0] prog_data;

  int n_chk = 0, n_bad = 0;
  int mdl [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  sereep_slave dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sk(sk), .di(di), .wr_abort(wr_abort),
    .do_out(do_out), .do_oe(do_oe), .prog_busy(prog_busy), .prog_valid(prog_valid),
    .prog_ready(prog_ready), .prog_addr(prog_addr), .prog_data(prog_data),
    .prog_all(prog_all)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_bit(input bit b);
    di = b; wait_n(HALF); sk = 1'b1; wait_n(HALF); sk = 1'b0;
  endtask

  task automatic send(input int val, input int n);
    for (int i = n - 1; i >= 0; i--) sk_bit(1'(val >> i));
  endtask

  task automatic sel();
    cs_n = 1'b0; wait_n(HALF);
  endtask

  task automatic desel();
    cs_n = 1'b1; di = 1'b0; wait_n(HALF + 2);
  endtask

  task automatic cmd(input int op, input int a);
    sel(); send(4'b1010, 4); send(op, 4); send(a, 8); wait_n(4); desel();
  endtask

  task automatic wr_frame(input int op, input int a, input int d);
    sel(); send(4'b1010, 4); send(op, 4); send(a, 8); send(d, 16); wait_n(HALF + 2);
    desel();
  endtask

  task automatic accept();
    prog_ready = 1'b1; wait_n(1); prog_ready = 1'b0; wait_n(1);
  endtask

  task automatic do_read(input int a, input bit junk, output int w, output bit oe_ok, output bit rel_ok);
    w = 0; oe_ok = 1'b1;
    sel();
    if (junk) send(3'b011, 3);
    send(4'b1010, 4); send(4'b1000, 4); send(a, 8);
    for (int k = 0; k < 16; k++) begin
      wait_n(HALF);
      w = (w << 1) | int'(do_out);
      if (!do_oe) oe_ok = 1'b0;
      sk = 1'b1; wait_n(HALF); sk = 1'b0;
    end
    wait_n(HALF);
    rel_ok = !do_oe;
    desel();
  endtask

  task automatic read_chk(input int a, input bit junk, input string tag);
    int w; bit oe_ok, rel_ok;
    do_read(a, junk, w, oe_ok, rel_ok);
    chk(w == mdl[a] && oe_ok, tag, w, mdl[a]);
    chk(rel_ok, {tag, " release after 17th fall"}, 1, 0);
  endtask

  function automatic int sweep_addr(input int i);
    return (i * 8 + 3) & 255;
  endfunction

  function automatic int sweep_data(input int i);
    return ((i * 16'h9E37) ^ 16'h5A5A) & 16'hFFFF;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    wait_n(5); rst_n = 1'b1; wait_n(3);
    // R1 reset state
    chk(do_oe == 1'b0, "R1 reset do_oe", do_oe, 0);
    chk(prog_valid == 1'b0, "R4 reset prog_valid", prog_valid, 0);
    sel(); wait_n(4);
    chk(do_oe == 1'b0, "R1 selected idle do_oe", do_oe, 0);
    desel();

    // R4: write with latch clear
    wr_frame(4'b0100, 5, 16'h1234);
    chk(prog_valid == 1'b0, "R4 write without enable", prog_valid, 0);
    wr_frame(4'b0001, 0, 16'h1111);
    chk(prog_valid == 1'b0, "R4 write-all without enable", prog_valid, 0);

    // R9: partial enable then deselect
    sel(); send(4'b1010, 4); send(4'b0011, 4); send(2'b10, 2); desel();
    wr_frame(4'b0100, 6, 16'h2222);
    chk(prog_valid == 1'b0, "R9 partial enable discarded", prog_valid, 0);

    // R5: enable while abort held high
    wr_abort = 1'b1;
    cmd(4'b0011, 0);
    wr_abort = 1'b0; wait_n(4);

    // R6 sweep of writes
    for (int i = 0; i < 32; i++) begin
      int a, d;
      a = sweep_addr(i); d = sweep_data(i);
      wr_frame(4'b0100, a, d);
      chk(prog_valid && prog_addr == 8'(a) && prog_data == 16'(d) && !prog_all,
          "R6 write request", {prog_valid, prog_all, prog_addr, prog_data}, {1'b1, 1'b0, 8'(a), 16'(d)});
      accept();
      chk(prog_valid == 1'b0, "R8 valid drops after accept", prog_valid, 0);
      mdl[a] = d;
    end

    // R8 back-pressure
    wr_frame(4'b0100, 200, 16'h0F0F);
    wait_n(20);
    chk(prog_valid && prog_addr == 8'd200 && prog_data == 16'h0F0F,
        "R8 pending held", {prog_addr, prog_data}, {8'd200, 16'h0F0F});
    wr_frame(4'b0100, sweep_addr(2), 16'hF0F0);
    chk(prog_valid && prog_addr == 8'd200 && prog_data == 16'h0F0F,
        "R8 second write dropped", {prog_addr, prog_data}, {8'd200, 16'h0F0F});
    accept();
    chk(prog_valid == 1'b0, "R8 accepted", prog_valid, 0);
    mdl[200] = 16'h0F0F;
    read_chk(sweep_addr(2), 1'b0, "R8 dropped write left word");
    read_chk(200, 1'b0, "R6 pending write landed");

    // R3 read sweep, R2 junk prefix, R5 reads under abort
    for (int i = 0; i < 32; i++) begin
      wr_abort = (i % 4 == 1);
      read_chk(sweep_addr(i), (i % 3 == 0), (i % 4 == 1) ? "R5 read under abort" :
               (i % 3 == 0) ? "R2 junk then read" : "R3 read word");
    end
    wr_abort = 1'b0;

    // R9: partial write then a clean read
    sel(); send(4'b1010, 4); send(4'b0100, 4); send(8'd3, 8); send(8'hAB, 8); desel();
    chk(prog_valid == 1'b0, "R9 partial write no request", prog_valid, 0);
    read_chk(3, 1'b0, "R9 read after discarded frame");

    // R10: abort in mid data
    sel(); send(4'b1010, 4); send(4'b0100, 4); send(11, 8); send(8'h77, 8);
    wr_abort = 1'b1; send(8'h88, 8); wait_n(HALF + 2);
    chk(prog_valid == 1'b0, "R10 aborted write", prog_valid, 0);
    desel(); wr_abort = 1'b0; wait_n(4);
    read_chk(11, 1'b0, "R10 word unchanged");

    // R5: disable blocks writes
    cmd(4'b0000, 0);
    wr_frame(4'b0100, 19, 16'hDEAD);
    chk(prog_valid == 1'b0, "R5 write after disable", prog_valid, 0);
    read_chk(19, 1'b0, "R5 word unchanged after disable");

    // R7 write-all
    cmd(4'b0011, 0);
    wr_frame(4'b0001, 8'h5C, 16'hC3A5);
    chk(prog_valid && prog_all && prog_data == 16'hC3A5, "R7 write-all request",
        {prog_all, prog_data}, {1'b1, 16'hC3A5});
    accept();
    for (int i = 0; i < 256; i++) mdl[i] = 16'hC3A5;
    read_chk(0, 1'b0, "R7 all words addr 0");
    read_chk(77, 1'b0, "R7 all words addr 77");
    read_chk(255, 1'b0, "R7 all words addr 255");

    // R11 status on data-out
    prog_busy = 1'b1;
    sel(); wait_n(4);
    chk(do_oe && !do_out, "R11 busy status", {do_oe, do_out}, 2'b10);
    prog_busy = 1'b0; wait_n(2);
    chk(do_oe && do_out, "R11 ready status", {do_oe, do_out}, 2'b11);
    sk_bit(1'b1); wait_n(4);
    chk(do_oe == 1'b0, "R11 released by di=1", do_oe, 0);
    desel();
    prog_busy = 1'b1; sel(); wait_n(4); prog_busy = 1'b0;
    desel();
    chk(do_oe == 1'b0, "R11 released by deselect", do_oe, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule